// File: doc/BRIEF.md
# Short Forward Branch Predication Pairing Unit

This unit sits in the issue stage of a simple in-order, dual-pipe core and looks at the two oldest decoded instructions. Slot 0 may hold a conditional branch whose target lies exactly one 32-bit instruction ahead. Slot 1 may hold a plain integer ALU instruction. When both hold, the pair is issued together on the two pipes. No branch redirect is raised, and the program counter moves past both instructions.

The ALU instruction always executes. The branch comparison, made on the two register operands supplied with the issue window, decides only whether the ALU result reaches the register file. A taken branch drops the write. A not-taken branch commits it, unless the destination is x0. In effect a short forward branch becomes a predicated write with no pipeline flush.

All results are registered and appear one clock after the instruction window is presented.

Top module: `shadow_pred_issue`

## Requirements
- R1: A pair forms only when slot 0 holds a branch (opcode 1100011) with a supported condition and a B-type immediate of exactly +8 bytes. Backward branches and any other offset are issued singly.
- R2: Slot 1 must be an integer ALU instruction to pair: opcode 0110011, 0010011, 0110111 or 0010111. Loads (0000011), stores (0100011), jumps (1101111), branches and system instructions (1110011) prevent pairing.
- R3: The branch condition is selected by funct3: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. The result is reported on `br_taken` for any valid supported branch, paired or not. funct3 010 and 011 are not branches and report not taken.
- R4: For a paired issue, `alu_wb_en` is high only when the branch is not taken. `alu_wb_rd` then carries slot 1's destination field (bits 11:7), and it is zero when no pair is issued.
- R5: A paired ALU instruction whose destination is x0 never raises `alu_wb_en`.
- R6: `redirect_kill` is high exactly when a pair is issued.
- R7: `pc_step` is 8 for a paired issue, 4 for a valid unpaired issue and 0 when no window is valid.
- R8: Every output is registered one cycle after the input window. With `in_valid` low, all outputs are zero in the next cycle.
- R9: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue window holds valid instructions |
| slot0_instr | input | 32 | Older instruction (candidate branch) |
| slot1_instr | input | 32 | Younger instruction (candidate shadow) |
| br_op_a | input | 32 | First branch source operand value |
| br_op_b | input | 32 | Second branch source operand value |
| pair_issue | output | 1 | Both slots issued as a predicated pair |
| alu_wb_en | output | 1 | Commit the shadow ALU result |
| alu_wb_rd | output | 5 | Destination register of the paired ALU instruction |
| redirect_kill | output | 1 | Suppress the front-end redirect for the branch |
| br_taken | output | 1 | Evaluated branch outcome |
| pc_step | output | 4 | Bytes the program counter advances |

## Verification
Every output is a single register stage after its inputs. The result of a window driven on a falling edge is therefore due on the next rising edge and is read at the falling edge after it. The bench drives a new window only after that read, so results from different windows never overlap. Reset is checked the same way: it is asserted across one rising edge and the outputs are read at the following falling edge.

// File: rtl/spi_pkg.sv
package spi_pkg;

   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

   typedef enum logic [2:0] {
      CND_EQ  = 3'b000,
      CND_NE  = 3'b001,
      CND_R2  = 3'b010,
      CND_R3  = 3'b011,
      CND_LT  = 3'b100,
      CND_GE  = 3'b101,
      CND_LTU = 3'b110,
      CND_GEU = 3'b111
   } cond_e;

   function automatic logic cond_supported(input logic [2:0] f3);
      return (f3 != CND_R2) && (f3 != CND_R3);
   endfunction

   function automatic logic is_reg_alu(input logic [6:0] opc);
      return (opc == OPC_OP) || (opc == OPC_OPIMM);
   endfunction

   function automatic logic is_upper_alu(input logic [6:0] opc);
      return (opc == OPC_LUI) || (opc == OPC_AUIPC);
   endfunction

endpackage

// File: rtl/spi_pair_detect.sv
module spi_pair_detect
   import spi_pkg::*;
#(
   parameter int INSTR_W     = 32,
   parameter int BR_OFFSET   = 8,
   parameter bit ALLOW_UPPER = 1'b1
) (
   input  logic [INSTR_W-1:0] slot0,
   input  logic [INSTR_W-1:0] slot1,
   output logic               is_branch,
   output logic               qualify,
   output logic [2:0]         cond,
   output logic [4:0]         shadow_rd
);
   localparam int IMM_W = 13;
   localparam logic [IMM_W-1:0] OFF_ENC = IMM_W'(BR_OFFSET);

   if (INSTR_W != 32) begin : g_bad_width
      $error("spi_pair_detect: INSTR_W must be 32");
   end
   if (BR_OFFSET <= 0 || (BR_OFFSET % 2) != 0 || BR_OFFSET >= 4096) begin : g_bad_off
      $error("spi_pair_detect: BR_OFFSET must be a positive even value below 4096");
   end

   logic [IMM_W-1:0] br_imm;
   logic             shadow_alu;

   assign cond      = slot0[14:12];
   assign br_imm    = {slot0[31], slot0[7], slot0[30:25], slot0[11:8], 1'b0};
   assign is_branch = (slot0[6:0] == OPC_BRANCH) && cond_supported(cond);
   assign shadow_rd = slot1[11:7];

   if (ALLOW_UPPER) begin : g_with_upper
      assign shadow_alu = is_reg_alu(slot1[6:0]) || is_upper_alu(slot1[6:0]);
   end else begin : g_reg_only
      assign shadow_alu = is_reg_alu(slot1[6:0]);
   end

   assign qualify = is_branch && (br_imm == OFF_ENC) && shadow_alu;

endmodule

// File: rtl/spi_cond_eval.sv
module spi_cond_eval
   import spi_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CMP_STYLE = 1
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic [2:0]      cond,
   output logic            taken
);
   if (XLEN < 2) begin : g_bad_xlen
      $error("spi_cond_eval: XLEN must be at least 2");
   end

   logic eq, lt_s, lt_u;

   assign eq = (op_a == op_b);

   if (CMP_STYLE == 1) begin : g_sub
      logic [XLEN:0] diff;
      assign diff = {1'b0, op_a} - {1'b0, op_b};
      assign lt_u = diff[XLEN];
      assign lt_s = (op_a[XLEN-1] ^ op_b[XLEN-1]) ? op_a[XLEN-1] : lt_u;
   end else begin : g_rel
      assign lt_u = (op_a < op_b);
      assign lt_s = ($signed(op_a) < $signed(op_b));
   end

   always_comb begin
      unique case (cond)
         CND_EQ:  taken = eq;
         CND_NE:  taken = !eq;
         CND_LT:  taken = lt_s;
         CND_GE:  taken = !lt_s;
         CND_LTU: taken = lt_u;
         CND_GEU: taken = !lt_u;
         default: taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/shadow_pred_issue.sv
module shadow_pred_issue
   import spi_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int INSTR_W     = 32,
   parameter int BR_OFFSET   = 8,
   parameter bit ALLOW_UPPER = 1'b1,
   parameter int CMP_STYLE   = 1,
   localparam int INSTR_B    = INSTR_W / 8,
   localparam int STEP_W     = $clog2(2 * INSTR_B + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] slot0_instr,
   input  logic [INSTR_W-1:0] slot1_instr,
   input  logic [XLEN-1:0]    br_op_a,
   input  logic [XLEN-1:0]    br_op_b,
   output logic               pair_issue,
   output logic               alu_wb_en,
   output logic [4:0]         alu_wb_rd,
   output logic               redirect_kill,
   output logic               br_taken,
   output logic [STEP_W-1:0]  pc_step
);
   localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(INSTR_B);
   localparam logic [STEP_W-1:0] PAIR_STEP = STEP_W'(2 * INSTR_B);

   if (BR_OFFSET != 2 * INSTR_B) begin : g_bad_cfg
      $error("shadow_pred_issue: BR_OFFSET must skip exactly one instruction");
   end

   logic       is_branch, qualify, taken;
   logic [2:0] cond;
   logic [4:0] shadow_rd;

   spi_pair_detect #(
      .INSTR_W    (INSTR_W),
      .BR_OFFSET  (BR_OFFSET),
      .ALLOW_UPPER(ALLOW_UPPER)
   ) detect_i (
      .slot0    (slot0_instr),
      .slot1    (slot1_instr),
      .is_branch(is_branch),
      .qualify  (qualify),
      .cond     (cond),
      .shadow_rd(shadow_rd)
   );

   spi_cond_eval #(
      .XLEN     (XLEN),
      .CMP_STYLE(CMP_STYLE)
   ) cond_i (
      .op_a (br_op_a),
      .op_b (br_op_b),
      .cond (cond),
      .taken(taken)
   );

   logic pair_d, wb_d;
   assign pair_d = in_valid && qualify;
   assign wb_d   = pair_d && !taken && (shadow_rd != 5'd0);

   always_ff @(posedge clk) begin
      if (rst) begin
         pair_issue    <= 1'b0;
         alu_wb_en     <= 1'b0;
         alu_wb_rd     <= 5'd0;
         redirect_kill <= 1'b0;
         br_taken      <= 1'b0;
         pc_step       <= '0;
      end else begin
         pair_issue    <= pair_d;
         alu_wb_en     <= wb_d;
         alu_wb_rd     <= pair_d ? shadow_rd : 5'd0;
         redirect_kill <= pair_d;
         br_taken      <= in_valid && is_branch && taken;
         pc_step       <= !in_valid ? '0 : (qualify ? PAIR_STEP : ONE_STEP);
      end
   end

   // R4: a taken branch must never let the shadow result through
   assert_taken_blocks_wb_R4: assert property (@(posedge clk) disable iff (rst)
      (pair_issue && br_taken) |-> !alu_wb_en);

   // R5: register zero is never written
   assert_x0_never_written_R5: assert property (@(posedge clk) disable iff (rst)
      alu_wb_en |-> (alu_wb_rd != 5'd0));

   // R7: a paired issue always advances past both instructions
   assert_step_paired_R7: assert property (@(posedge clk) disable iff (rst)
      pair_issue |-> (pc_step == PAIR_STEP));

   // R8: an idle window leaves every output quiet one cycle later
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      $past(!in_valid) |-> (!pair_issue && !br_taken && pc_step == '0));

   // R2: a pair only forms over an ALU-class shadow instruction
   assert_shadow_is_alu_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(pair_issue) |-> (is_reg_alu($past(slot1_instr[6:0])) ||
                             is_upper_alu($past(slot1_instr[6:0]))));

endmodule

// File: tb/shadow_pred_issue_tb_top.sv
`timescale 1ns/1ps
module shadow_pred_issue_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] slot0_instr = '0, slot1_instr = '0, br_op_a = '0, br_op_b = '0;
   logic        pair_issue, alu_wb_en, redirect_kill, br_taken;
   logic [4:0]  alu_wb_rd;
   logic [3:0]  pc_step;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   shadow_pred_issue dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .slot0_instr(slot0_instr), .slot1_instr(slot1_instr),
      .br_op_a(br_op_a), .br_op_b(br_op_b),
      .pair_issue(pair_issue), .alu_wb_en(alu_wb_en), .alu_wb_rd(alu_wb_rd),
      .redirect_kill(redirect_kill), .br_taken(br_taken), .pc_step(pc_step)
   );

   function automatic logic [31:0] enc_b(input logic [2:0] f3, input int imm);
      logic [12:0] m;
      m = 13'(imm);
      return {m[12], m[10:5], 5'd2, 5'd1, f3, m[4:1], m[11], 7'b1100011};
   endfunction

   function automatic logic [31:0] enc_r(input logic [4:0] rd);
      return {7'd0, 5'd2, 5'd1, 3'b000, rd, 7'b0110011};
   endfunction

   function automatic logic [31:0] enc_i(input logic [6:0] opc, input logic [4:0] rd);
      return {12'd5, 5'd1, 3'b000, rd, opc};
   endfunction

   function automatic logic [31:0] enc_u(input logic [6:0] opc, input logic [4:0] rd);
      return {20'h12345, rd, opc};
   endfunction

   typedef struct packed {
      logic [31:0] s0;
      logic [31:0] s1;
      logic [31:0] a;
      logic [31:0] b;
      logic        pair;
      logic        wb;
      logic        taken;
      logic [3:0]  step;
      logic [4:0]  rd;
   } vec_t;

   localparam logic [31:0] NEG1 = 32'hFFFF_FFFF;
   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{enc_b(3'b000, 8), enc_r(5'd5), 32'd3, 32'd3, 1'b1, 1'b0, 1'b1, 4'd8, 5'd5},
      '{enc_b(3'b000, 8), enc_r(5'd5), 32'd3, 32'd4, 1'b1, 1'b1, 1'b0, 4'd8, 5'd5},
      '{enc_b(3'b001, 8), enc_i(7'b0010011, 5'd6), 32'd3, 32'd4, 1'b1, 1'b0, 1'b1, 4'd8, 5'd6},
      '{enc_b(3'b100, 8), enc_u(7'b0110111, 5'd7), NEG1, 32'd1, 1'b1, 1'b0, 1'b1, 4'd8, 5'd7},
      '{enc_b(3'b110, 8), enc_u(7'b0010111, 5'd7), NEG1, 32'd1, 1'b1, 1'b1, 1'b0, 4'd8, 5'd7},
      '{enc_b(3'b101, 8), enc_r(5'd8), 32'd1, NEG1, 1'b1, 1'b0, 1'b1, 4'd8, 5'd8},
      '{enc_b(3'b111, 8), enc_r(5'd8), 32'd1, NEG1, 1'b1, 1'b1, 1'b0, 4'd8, 5'd8},
      '{enc_b(3'b101, 8), enc_r(5'd9), 32'd7, 32'd7, 1'b1, 1'b0, 1'b1, 4'd8, 5'd9},
      '{enc_b(3'b000, -8), enc_r(5'd5), 32'd3, 32'd3, 1'b0, 1'b0, 1'b1, 4'd4, 5'd0},
      '{enc_b(3'b000, 12), enc_r(5'd5), 32'd3, 32'd4, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0},
      '{enc_b(3'b000, 8), enc_i(7'b0000011, 5'd5), 32'd3, 32'd4, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0},
      '{enc_b(3'b000, 8), enc_i(7'b0100011, 5'd5), 32'd3, 32'd4, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0},
      '{enc_b(3'b000, 8), enc_u(7'b1101111, 5'd1), 32'd3, 32'd4, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0},
      '{enc_b(3'b000, 8), enc_i(7'b1110011, 5'd0), 32'd3, 32'd4, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0},
      '{enc_b(3'b001, 8), enc_r(5'd0), 32'd3, 32'd3, 1'b1, 1'b0, 1'b0, 4'd8, 5'd0},
      '{enc_r(5'd3), enc_r(5'd4), 32'd3, 32'd3, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0},
      '{enc_b(3'b000, 8), enc_b(3'b000, 8), 32'd3, 32'd4, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0},
      '{enc_b(3'b010, 8), enc_r(5'd5), 32'd3, 32'd3, 1'b0, 1'b0, 1'b0, 4'd4, 5'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all_zero(input string tag);
      chk({tag, " pair"}, 32'(pair_issue), 32'd0);
      chk({tag, " wb"},   32'(alu_wb_en), 32'd0);
      chk({tag, " rd"},   32'(alu_wb_rd), 32'd0);
      chk({tag, " kill"}, 32'(redirect_kill), 32'd0);
      chk({tag, " taken"},32'(br_taken), 32'd0);
      chk({tag, " step"}, 32'(pc_step), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_all_zero("R9 reset");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         slot0_instr = VECS[i].s0;
         slot1_instr = VECS[i].s1;
         br_op_a     = VECS[i].a;
         br_op_b     = VECS[i].b;
         in_valid    = 1'b1;
         @(negedge clk);
         in_valid    = 1'b0;
         chk($sformatf("R1 R2 pair v%0d", i), 32'(pair_issue), 32'(VECS[i].pair));
         chk($sformatf("R4 R5 wb v%0d", i),   32'(alu_wb_en), 32'(VECS[i].wb));
         chk($sformatf("R4 rd v%0d", i),      32'(alu_wb_rd), 32'(VECS[i].rd));
         chk($sformatf("R6 kill v%0d", i),    32'(redirect_kill), 32'(VECS[i].pair));
         chk($sformatf("R3 taken v%0d", i),   32'(br_taken), 32'(VECS[i].taken));
         chk($sformatf("R7 step v%0d", i),    32'(pc_step), 32'(VECS[i].step));
      end

      // R8: a qualifying window with in_valid low produces nothing
      @(negedge clk);
      slot0_instr = enc_b(3'b000, 8);
      slot1_instr = enc_r(5'd5);
      br_op_a = 32'd1;
      br_op_b = 32'd2;
      in_valid = 1'b0;
      @(negedge clk);
      check_all_zero("R8 idle");

      // R9: reset while a pair is presented clears the outputs
      in_valid = 1'b1;
      @(negedge clk);
      chk("R7 step before reset", 32'(pc_step), 32'd8);
      rst = 1'b1;
      @(negedge clk);
      check_all_zero("R9 mid reset");
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule